// File: doc/BRIEF.md
# Windowed Bus Data Trace Qualifier

This block sits beside a processor bus and picks out the completed data transfers that should become data trace records. It has two channels, and each is programmed on its own. A channel has a lower and an upper address bound, a mode bit that traces either inside or outside that window, separate enables for reads and writes, and a side selector. The side selector chooses between data moved for the data side and data moved for the instruction side.

A bus cycle opens with a start strobe that carries the address and the cycle attributes. It closes with a done, error or abort strobe, and the data comes with the done strobe. The block decides when the cycle opens whether each channel wants it. The configuration is sampled at that point. When the cycle closes cleanly, one record is produced for each qualifying channel. Each record holds the channel number, the direction, the address and the data. Records leave in capture order through a small FIFO with a valid/ready handshake. A record that finds the FIFO full is dropped and sets a sticky overflow flag.

Some cycles are always skipped: instruction fetches, cycles the debug logic starts itself, aborted cycles and cycles that end in error. A misaligned access that crosses a 64-bit boundary reaches the bus as two transactions. Each transaction is qualified on its own, so two records come out when both halves are in range.

Top module: `trace_window_qualifier`

## Requirements
- R1: In inside mode (`cfg_outside` bit = 0) a channel matches addresses with lower <= address <= upper, and both bounds are included. If lower > upper, no address matches.
- R2: In outside mode (`cfg_outside` bit = 1) a channel matches exactly the addresses that inside mode would reject. If lower > upper, every address matches.
- R3: A read (`bus_write` = 0) qualifies only when the channel's `cfg_rd_en` bit is 1. A write (`bus_write` = 1) qualifies only when its `cfg_wr_en` bit is 1.
- R4: A cycle qualifies only when `bus_iside` equals the channel's `cfg_iside` bit (1 = instruction-side data, 0 = data-side data).
- R5: A cycle started with `bus_fetch` = 1 or `bus_dbg` = 1 never produces a record.
- R6: A cycle closed by `bus_abort`, or by `bus_err` (even when `bus_done` is also high), produces no record.
- R7: A cycle that closes with `bus_done` alone produces one record per qualifying channel. Each record carries `rec_chan` (0 = first channel, 1 = second), the direction and address latched at start, and the `bus_data` present with `bus_done`. The record is visible on the record port from the cycle after the `bus_done` edge.
- R8: When both channels qualify the same cycle, the channel 0 record comes out before the channel 1 record.
- R9: A boundary-crossing access issued as two bus transactions gives one record set per transaction, in transaction order. That is two records from one channel when both halves are in its window.
- R10: The configuration is sampled at the `bus_start` edge. A change made while a cycle is open affects only later cycles.
- R11: The FIFO holds DEPTH records. Space is judged from the occupancy before a pop on the same edge, and channel 0 is served first. Records that find no space are dropped, `trace_ovf` becomes 1 and stays 1 until reset, and the records already held keep their order.
- R12: After reset, `rec_valid` = 0 and `trace_ovf` = 0.
- R13: While `rec_valid` = 1 and `rec_ready` = 0, the record fields hold steady and `rec_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lo | input | NCH*ADDR_W | Lower window bound per channel (channel i in slice i) |
| cfg_hi | input | NCH*ADDR_W | Upper window bound per channel |
| cfg_outside | input | NCH | Window mode per channel: 0 inside, 1 outside |
| cfg_rd_en | input | NCH | Trace reads per channel |
| cfg_wr_en | input | NCH | Trace writes per channel |
| cfg_iside | input | NCH | Side selector per channel: 1 instruction-side data, 0 data-side |
| bus_start | input | 1 | Opens a bus cycle; attributes are valid with it |
| bus_addr | input | ADDR_W | Cycle address, sampled with `bus_start` |
| bus_write | input | 1 | Cycle direction: 1 write, 0 read |
| bus_iside | input | 1 | Cycle moves instruction-side data |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_dbg | input | 1 | Cycle was started by the debug logic |
| bus_done | input | 1 | Cycle completed |
| bus_err | input | 1 | Cycle ended with a transfer error |
| bus_abort | input | 1 | Cycle was aborted |
| bus_data | input | DATA_W | Transfer data, valid with `bus_done` |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_chan | output | CH_W | Channel that produced the record |
| rec_write | output | 1 | Record direction |
| rec_addr | output | ADDR_W | Record address |
| rec_data | output | DATA_W | Record data |
| trace_ovf | output | 1 | Sticky flag: a record was dropped |

## Verification
Every bus stimulus is applied just after a falling edge. The window decision is latched on the rising edge that takes `bus_start`, and records are written on the rising edge that takes `bus_done`. They are therefore due on the record port at the next falling-edge sample, one cycle after the done strobe. A pop or a dropped record also shows at the following sample. The bench keeps a model queue that it updates in the same cycle as the design's edges, and it compares the port values against that queue at every falling edge, so no result is read early or late. After each directed case the bench drains the queue and compares the record count with a hand-derived figure.

// File: rtl/twq_pkg.sv
package twq_pkg;

   typedef enum logic {
      WIN_INSIDE  = 1'b0,
      WIN_OUTSIDE = 1'b1
   } win_mode_e;

   // direction gate: reads and writes have their own enable
   function automatic logic dir_enabled(input logic is_wr, input logic rd_en,
                                        input logic wr_en);
      return is_wr ? wr_en : rd_en;
   endfunction

endpackage

// File: rtl/twq_chan_qual.sv
module twq_chan_qual
   import twq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_wr,
   input  logic              iside,
   input  logic              fetch,
   input  logic              dbg,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic              outside,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              sel_iside,
   output logic              hit
);
   logic in_win;
   logic win_ok;

   // inclusive bounds; lo > hi leaves the window empty
   assign in_win = (addr >= lo) && (addr <= hi);
   assign win_ok = (win_mode_e'(outside) == WIN_OUTSIDE) ? !in_win : in_win;

   assign hit = win_ok && dir_enabled(is_wr, rd_en, wr_en) &&
                (iside == sel_iside) && !fetch && !dbg;
endmodule

// File: rtl/twq_cycle_track.sv
module twq_cycle_track #(
   parameter int ADDR_W = 32,
   parameter int NCH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic              bus_done,
   input  logic              bus_err,
   input  logic              bus_abort,
   input  logic [NCH-1:0]    hit,
   output logic [NCH-1:0]    push,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_write
);
   logic           active_q;
   logic [NCH-1:0] pend_q;
   logic           clean_end;

   assign clean_end = bus_done && !bus_err && !bus_abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         pend_q    <= '0;
         cur_addr  <= '0;
         cur_write <= 1'b0;
      end else if (bus_start) begin
         active_q  <= 1'b1;
         pend_q    <= hit;
         cur_addr  <= bus_addr;
         cur_write <= bus_write;
      end else if (bus_done || bus_err || bus_abort) begin
         active_q  <= 1'b0;
         pend_q    <= '0;
      end
   end

   assign push = (active_q && clean_end) ? pend_q : '0;
endmodule

// File: rtl/twq_rec_fifo.sv
module twq_rec_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int NWR   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NWR-1:0] wr_req,
   input  logic [NWR*W-1:0] wr_data,
   output logic           rd_valid,
   input  logic           rd_ready,
   output logic [W-1:0]   rd_data,
   output logic           drop
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] nacc;
   logic [NWR-1:0]   acc;
   logic [PTR_W-1:0] widx [NWR];
   logic             pop;

   // lower index first; space judged before this edge's pop
   always_comb begin
      nacc = '0;
      for (int i = 0; i < NWR; i++) begin
         widx[i] = wptr + nacc[PTR_W-1:0];
         acc[i]  = wr_req[i] && ((cnt + nacc) < CNT_W'(DEPTH));
         if (acc[i]) nacc = nacc + CNT_W'(1);
      end
   end

   assign drop     = |(wr_req & ~acc);
   assign rd_valid = (cnt != '0);
   assign rd_data  = mem[rptr];
   assign pop      = rd_valid && rd_ready;

   always_ff @(posedge clk) begin
      for (int i = 0; i < NWR; i++) begin
         if (acc[i]) mem[widx[i]] <= wr_data[i*W +: W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         wptr <= wptr + nacc[PTR_W-1:0];
         if (pop) rptr <= rptr + PTR_W'(1);
         cnt  <= cnt + nacc - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/trace_window_qualifier.sv
module trace_window_qualifier #(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 64,
   parameter  int NCH    = 2,
   parameter  int DEPTH  = 4,
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH*ADDR_W-1:0] cfg_lo,
   input  logic [NCH*ADDR_W-1:0] cfg_hi,
   input  logic [NCH-1:0]        cfg_outside,
   input  logic [NCH-1:0]        cfg_rd_en,
   input  logic [NCH-1:0]        cfg_wr_en,
   input  logic [NCH-1:0]        cfg_iside,
   input  logic                  bus_start,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_write,
   input  logic                  bus_iside,
   input  logic                  bus_fetch,
   input  logic                  bus_dbg,
   input  logic                  bus_done,
   input  logic                  bus_err,
   input  logic                  bus_abort,
   input  logic [DATA_W-1:0]     bus_data,
   output logic                  rec_valid,
   input  logic                  rec_ready,
   output logic [CH_W-1:0]       rec_chan,
   output logic                  rec_write,
   output logic [ADDR_W-1:0]     rec_addr,
   output logic [DATA_W-1:0]     rec_data,
   output logic                  trace_ovf
);
   localparam int REC_W = CH_W + 1 + ADDR_W + DATA_W;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < 4 || DATA_W < 8) begin : g_bad_width
      $error("ADDR_W or DATA_W too small");
   end

   logic [NCH-1:0]       hit;
   logic [NCH-1:0]       push;
   logic [ADDR_W-1:0]    trk_addr;
   logic                 trk_write;
   logic [NCH*REC_W-1:0] wr_data;
   logic [REC_W-1:0]     rd_data;
   logic                 drop;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      twq_chan_qual #(.ADDR_W(ADDR_W)) u_qual (
         .addr      (bus_addr),
         .is_wr     (bus_write),
         .iside     (bus_iside),
         .fetch     (bus_fetch),
         .dbg       (bus_dbg),
         .lo        (cfg_lo[c*ADDR_W +: ADDR_W]),
         .hi        (cfg_hi[c*ADDR_W +: ADDR_W]),
         .outside   (cfg_outside[c]),
         .rd_en     (cfg_rd_en[c]),
         .wr_en     (cfg_wr_en[c]),
         .sel_iside (cfg_iside[c]),
         .hit       (hit[c])
      );
      assign wr_data[c*REC_W +: REC_W] = {CH_W'(c), trk_write, trk_addr, bus_data};
   end

   twq_cycle_track #(.ADDR_W(ADDR_W), .NCH(NCH)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_start (bus_start),
      .bus_addr  (bus_addr),
      .bus_write (bus_write),
      .bus_done  (bus_done),
      .bus_err   (bus_err),
      .bus_abort (bus_abort),
      .hit       (hit),
      .push      (push),
      .cur_addr  (trk_addr),
      .cur_write (trk_write)
   );

   twq_rec_fifo #(.W(REC_W), .DEPTH(DEPTH), .NWR(NCH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (push),
      .wr_data  (wr_data),
      .rd_valid (rec_valid),
      .rd_ready (rec_ready),
      .rd_data  (rd_data),
      .drop     (drop)
   );

   assign {rec_chan, rec_write, rec_addr, rec_data} = rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trace_ovf <= 1'b0;
      else if (drop) trace_ovf <= 1'b1;
   end
endmodule

// File: rtl/twq_checker.sv
module twq_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int NCH    = 2,
   parameter int DEPTH  = 4,
   parameter int CH_W   = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_start,
   input logic                     bus_fetch,
   input logic                     bus_dbg,
   input logic                     bus_err,
   input logic                     bus_abort,
   input logic                     rec_valid,
   input logic                     rec_ready,
   input logic [CH_W-1:0]          rec_chan,
   input logic                     rec_write,
   input logic [ADDR_W-1:0]        rec_addr,
   input logic [DATA_W-1:0]        rec_data,
   input logic                     trace_ovf,
   input logic [NCH-1:0]           pend,
   input logic [$clog2(DEPTH):0]   fifo_cnt
);
   p_skip_fetch_dbg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start && (bus_fetch || bus_dbg) |=> pend == '0);

   p_no_record_on_bad_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err || bus_abort) |=> fifo_cnt <= $past(fifo_cnt));

   p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

   p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trace_ovf |=> trace_ovf);

   p_valid_matches_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid == (fifo_cnt != '0));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=>
         rec_valid && $stable({rec_chan, rec_write, rec_addr, rec_data}));
endmodule

bind trace_window_qualifier twq_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .DEPTH(DEPTH), .CH_W(CH_W)
) u_twq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_start (bus_start),
   .bus_fetch (bus_fetch),
   .bus_dbg   (bus_dbg),
   .bus_err   (bus_err),
   .bus_abort (bus_abort),
   .rec_valid (rec_valid),
   .rec_ready (rec_ready),
   .rec_chan  (rec_chan),
   .rec_write (rec_write),
   .rec_addr  (rec_addr),
   .rec_data  (rec_data),
   .trace_ovf (trace_ovf),
   .pend      (u_track.pend_q),
   .fifo_cnt  (u_fifo.cnt)
);

// File: tb/trace_window_qualifier_bench.sv
module trace_window_qualifier_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int NCH = 2;
   localparam int DEPTH = 4;

   typedef struct packed {
      logic [0:0]    ch;
      logic          wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } rec_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] c_lo [NCH];
   logic [AW-1:0] c_hi [NCH];
   logic [NCH-1:0] c_out, c_rd, c_wr, c_is;
   logic [NCH*AW-1:0] cfg_lo, cfg_hi;
   logic bus_start = 0, bus_write = 0, bus_iside = 0, bus_fetch = 0, bus_dbg = 0;
   logic bus_done = 0, bus_err = 0, bus_abort = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic rec_valid, rec_ready = 0, rec_write, trace_ovf;
   logic [0:0] rec_chan;
   logic [AW-1:0] rec_addr;
   logic [DW-1:0] rec_data;

   assign cfg_lo = {c_lo[1], c_lo[0]};
   assign cfg_hi = {c_hi[1], c_hi[0]};

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_window_qualifier #(.ADDR_W(AW), .DATA_W(DW), .NCH(NCH), .DEPTH(DEPTH))
   u_trace_window_qualifier (
      .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .cfg_outside(c_out), .cfg_rd_en(c_rd), .cfg_wr_en(c_wr), .cfg_iside(c_is),
      .bus_start(bus_start), .bus_addr(bus_addr), .bus_write(bus_write),
      .bus_iside(bus_iside), .bus_fetch(bus_fetch), .bus_dbg(bus_dbg),
      .bus_done(bus_done), .bus_err(bus_err), .bus_abort(bus_abort),
      .bus_data(bus_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_chan(rec_chan), .rec_write(rec_write), .rec_addr(rec_addr),
      .rec_data(rec_data), .trace_ovf(trace_ovf)
   );

   int    checks = 0;
   int    failures = 0;
   bit    finished = 0;
   string cur_req = "R12";
   rec_t  mq[$];
   bit    m_active = 0;
   bit [NCH-1:0] m_pend = '0;
   bit    m_ovf = 0;
   int    m_pushed = 0;
   bit    rdy_hold = 0;
   bit    rdy_all = 0;

   task automatic check(input bit ok, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // expected channel decision from the requirements (R1..R5)
   function automatic bit exp_hit(int c, logic [AW-1:0] a, logic w, logic is,
                                  logic f, logic d);
      bit inw, win;
      inw = (a >= c_lo[c]) && (a <= c_hi[c]);
      win = c_out[c] ? !inw : inw;
      return win && (w ? c_wr[c] : c_rd[c]) && (is == c_is[c]) && !f && !d;
   endfunction

   task automatic tick();
      rec_t nw[$];
      int   occ, n;
      bit   pop;
      rec_ready = rdy_hold ? 1'b0 : (rdy_all ? 1'b1 : ($urandom % 4 != 0));
      check(rec_valid === (mq.size() > 0), "rec_valid", 128'(rec_valid), 128'(mq.size() > 0));
      if (mq.size() > 0)
         check({rec_chan, rec_write, rec_addr, rec_data} === mq[0], "record",
               128'({rec_chan, rec_write, rec_addr, rec_data}), 128'(mq[0]));
      check(trace_ovf === m_ovf, "trace_ovf", 128'(trace_ovf), 128'(m_ovf));
      pop = (mq.size() > 0) && rec_ready;
      if (m_active && bus_done && !bus_err && !bus_abort) begin
         occ = mq.size();
         n = 0;
         for (int c = 0; c < NCH; c++) begin
            if (m_pend[c]) begin
               if (occ + n < DEPTH) begin
                  nw.push_back(rec_t'{ch: 1'(c), wr: bus_write_q, addr: bus_addr_q, data: bus_data});
                  n++;
               end else m_ovf = 1;
            end
         end
      end
      if (pop) void'(mq.pop_front());
      foreach (nw[i]) begin
         mq.push_back(nw[i]);
         m_pushed++;
      end
      if (bus_start) begin
         m_active = 1;
         for (int c = 0; c < NCH; c++)
            m_pend[c] = exp_hit(c, bus_addr, bus_write, bus_iside, bus_fetch, bus_dbg);
         bus_addr_q = bus_addr;
         bus_write_q = bus_write;
      end else if (bus_done || bus_err || bus_abort) begin
         m_active = 0;
         m_pend = '0;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   logic [AW-1:0] bus_addr_q = '0;
   logic          bus_write_q = 0;

   task automatic begin_cycle(input logic [AW-1:0] a, input logic w, input logic is,
                              input logic f, input logic d);
      bus_start = 1; bus_addr = a; bus_write = w; bus_iside = is;
      bus_fetch = f; bus_dbg = d;
      tick();
      bus_start = 0; bus_fetch = 0; bus_dbg = 0;
   endtask

   // endk: 0 done, 1 error (with done), 2 abort
   task automatic end_cycle(input int endk);
      bus_data = {$urandom, $urandom};
      bus_done = (endk != 2);
      bus_err = (endk == 1);
      bus_abort = (endk == 2);
      tick();
      bus_done = 0; bus_err = 0; bus_abort = 0;
   endtask

   task automatic xfer(input logic [AW-1:0] a, input logic w, input logic is,
                       input logic f, input logic d, input int endk);
      begin_cycle(a, w, is, f, d);
      repeat ($urandom % 3) tick();
      end_cycle(endk);
   endtask

   task automatic set_ch(input int c, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                         input logic o, input logic r, input logic w, input logic is);
      c_lo[c] = lo; c_hi[c] = hi; c_out[c] = o; c_rd[c] = r; c_wr[c] = w; c_is[c] = is;
   endtask

   task automatic phase(input string r);
      cur_req = r;
      m_pushed = 0;
   endtask

   task automatic expect_count(input int n);
      rdy_all = 1;
      repeat (DEPTH + 4) tick();
      rdy_all = 0;
      check(mq.size() == 0 && !rec_valid, "drained", 128'(rec_valid), 128'(0));
      check(m_pushed == n, "record count", 128'(m_pushed), 128'(n));
   endtask

   initial begin
      void'($urandom(32'h1d5e_ed01));
      for (int c = 0; c < NCH; c++) set_ch(c, '0, '0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      cur_req = "R12";
      check(rec_valid === 1'b0, "reset rec_valid", 128'(rec_valid), 128'(0));
      check(trace_ovf === 1'b0, "reset trace_ovf", 128'(trace_ovf), 128'(0));
      rst_n = 1;
      tick();

      // R1: inclusive inside window, then empty window
      phase("R1");
      set_ch(0, 32'h100, 32'h1FF, 0, 1, 1, 0);
      xfer(32'h0FF, 0, 0, 0, 0, 0);
      xfer(32'h100, 0, 0, 0, 0, 0);
      xfer(32'h1FF, 1, 0, 0, 0, 0);
      xfer(32'h200, 0, 0, 0, 0, 0);
      expect_count(2);
      phase("R1");
      set_ch(0, 32'h300, 32'h200, 0, 1, 1, 0);
      xfer(32'h250, 0, 0, 0, 0, 0);
      expect_count(0);

      // R2: outside mode
      phase("R2");
      set_ch(0, 32'h100, 32'h1FF, 1, 1, 1, 0);
      xfer(32'h100, 0, 0, 0, 0, 0);
      xfer(32'h080, 0, 0, 0, 0, 0);
      xfer(32'h200, 1, 0, 0, 0, 0);
      expect_count(2);
      phase("R2");
      set_ch(0, 32'h300, 32'h200, 1, 1, 1, 0);
      xfer(32'h250, 0, 0, 0, 0, 0);
      expect_count(1);

      // R3: direction enables
      phase("R3");
      set_ch(0, 32'h0, 32'hFFFF, 0, 1, 0, 0);
      xfer(32'h10, 1, 0, 0, 0, 0);
      xfer(32'h10, 0, 0, 0, 0, 0);
      set_ch(0, 32'h0, 32'hFFFF, 0, 0, 1, 0);
      xfer(32'h18, 0, 0, 0, 0, 0);
      xfer(32'h18, 1, 0, 0, 0, 0);
      expect_count(2);

      // R4: side selector
      phase("R4");
      set_ch(0, 32'h0, 32'hFFFF, 0, 1, 1, 1);
      xfer(32'h20, 0, 0, 0, 0, 0);
      xfer(32'h20, 0, 1, 0, 0, 0);
      expect_count(1);

      // R5: fetch and debug-initiated cycles
      phase("R5");
      set_ch(0, 32'h0, 32'hFFFF, 0, 1, 1, 0);
      xfer(32'h30, 0, 0, 1, 0, 0);
      xfer(32'h30, 1, 0, 0, 1, 0);
      expect_count(0);

      // R6: abort and error endings
      phase("R6");
      xfer(32'h40, 0, 0, 0, 0, 2);
      xfer(32'h40, 1, 0, 0, 0, 1);
      expect_count(0);

      // R8: both channels on one cycle; order checked by the scoreboard
      phase("R8");
      set_ch(1, 32'h0, 32'hFFFF, 0, 1, 1, 0);
      xfer(32'h50, 1, 0, 0, 0, 0);
      expect_count(2);

      // R9: access split at a 64-bit boundary: two transactions
      phase("R9");
      set_ch(1, 32'h0, 32'h0, 0, 0, 0, 0);
      set_ch(0, 32'h100, 32'h2FF, 0, 1, 1, 0);
      xfer(32'h1FC, 1, 0, 0, 0, 0);
      xfer(32'h200, 1, 0, 0, 0, 0);
      expect_count(2);
      phase("R9");
      set_ch(1, 32'h100, 32'h2FF, 0, 1, 1, 0);
      xfer(32'h1FC, 0, 0, 0, 0, 0);
      xfer(32'h200, 0, 0, 0, 0, 0);
      expect_count(4);

      // R10: config sampled at start
      phase("R10");
      set_ch(1, 32'h0, 32'h0, 0, 0, 0, 0);
      set_ch(0, 32'h0, 32'hFFFF, 0, 1, 1, 0);
      begin_cycle(32'h60, 0, 0, 0, 0);
      c_rd[0] = 0;
      tick();
      end_cycle(0);
      begin_cycle(32'h60, 0, 0, 0, 0);
      c_rd[0] = 1;
      tick();
      end_cycle(0);
      expect_count(1);

      // R11 / R13: full FIFO drops, sticky flag, held output
      phase("R13");
      set_ch(1, 32'h0, 32'hFFFF, 0, 1, 1, 0);
      rdy_hold = 1;
      xfer(32'h70, 1, 0, 0, 0, 0);
      xfer(32'h78, 0, 0, 0, 0, 0);
      repeat (3) tick();
      cur_req = "R11";
      check(trace_ovf === 1'b0, "no overflow yet", 128'(trace_ovf), 128'(0));
      xfer(32'h80, 1, 0, 0, 0, 0);
      tick();
      check(trace_ovf === 1'b1, "overflow set", 128'(trace_ovf), 128'(1));
      rdy_hold = 0;
      expect_count(4);
      check(trace_ovf === 1'b1, "overflow sticky", 128'(trace_ovf), 128'(1));

      // R7: random traffic and configurations
      phase("R7");
      for (int k = 0; k < 300; k++) begin
         if (k % 15 == 0) begin
            for (int c = 0; c < NCH; c++)
               set_ch(c, AW'($urandom % 1024), AW'($urandom % 1024), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
         end
         xfer(AW'($urandom % 1024), 1'($urandom), 1'($urandom),
              1'(($urandom % 8) == 0), 1'(($urandom % 8) == 0),
              (($urandom % 6) == 0) ? 1 + int'($urandom % 2) : 0);
      end
      rdy_all = 1;
      repeat (DEPTH + 4) tick();
      check(mq.size() == 0 && !rec_valid, "final drain", 128'(rec_valid), 128'(0));

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog %s actual=hung expected=done", cur_req);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule